// File: doc/BRIEF.md
# Character Input Port with Read-to-Clear Interrupt

This block is a read-only peripheral on a 24-bit CPU bus. A character source presents an 8-bit ASCII code with a one-cycle valid strobe. The block latches that code into a holding register and raises an interrupt request. The request stays up until software reads the port. That read returns the latched code and is the only way to acknowledge the request.

The port decodes a single byte address (0x800000 by default). A read at that address returns the character on data bits 7..0, with the upper data bits at zero. The returned data is registered, and it stays on the output until the next acknowledged read.

A bus cycle may hold the select asserted for several clocks. Only the first clock of a matching read counts as an acknowledge, so a slow bus cycle cannot swallow a second character. Writes to the port address, and reads at any other address, leave the port untouched.

Top module: `keyin_port`

## Requirements
- R1: A synchronous active-high reset clears the interrupt request, the read data output and the holding register, so a read right after reset returns 0x00.
- R2: A cycle with `src_valid` high loads `src_char` into the holding register, and `irq` is high from the next clock edge.
- R3: A read (`bus_cs`=1, `bus_we`=0) at address 0x800000 puts the held character on `rd_data[7:0]` and drops `irq`, both from the clock edge that samples the first cycle of the access.
- R4: `rd_data[15:8]` is always zero.
- R5: Once raised, `irq` stays high through idle cycles until an acknowledged read.
- R6: A character that arrives before the previous one is read overwrites it, and `irq` stays high. The next read returns the newest character.
- R7: A read held for several cycles acknowledges only once. A character arriving during the held cycle keeps `irq` high, and a later separate read returns it.
- R8: A write (`bus_cs`=1, `bus_we`=1) to the port address neither clears `irq` nor changes `rd_data`.
- R9: A read at any address other than 0x800000 neither clears `irq` nor changes `rd_data`.
- R10: When a character arrives in the same cycle as an acknowledged read, the read returns the previously held character, the new one is kept, and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | One-cycle strobe: a new character is present |
| src_char | input | 8 | ASCII code from the character source |
| bus_cs | input | 1 | Bus cycle active |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 24 | Byte address |
| rd_data | output | 16 | Registered read data, character on bits 7..0 |
| irq | output | 1 | Interrupt request, high while a character is unread |

## Verification
The assertions assume that `src_valid` and `bus_cs` are clean single-bit levels sampled at the rising edge. They also assume that a bus access is marked by `bus_cs` and is not signalled again without `bus_cs` first going low. The stimulus changes inputs only on the falling clock edge. It drops `bus_cs` for at least one cycle between separate accesses, except in the held-read case, which keeps `bus_cs` high on purpose. It pairs a character strobe with a read start only in the one directed case that targets that collision.

// File: rtl/keyin_pkg.sv
package keyin_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/keyin_decode.sv
module keyin_decode
  import keyin_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 24'h800000
) (
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind
);
  logic hit;
  assign hit = cs && (addr == PORT_ADDR);

  always_comb begin
    kind = ACC_NONE;
    if (hit) kind = we ? ACC_WRITE : ACC_READ;
  end
endmodule

// File: rtl/keyin_rdpulse.sv
module keyin_rdpulse (
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  output logic ack
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= rd_req;
  end

  assign ack = rd_req && !req_q;

  // R7: an acknowledge never lasts two cycles
  p_single_ack_r7: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
endmodule

// File: rtl/keyin_hold.sv
module keyin_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [CHAR_W-1:0] ld_char,
  input  logic              ack,
  output logic [CHAR_W-1:0] held,
  output logic              pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      pend <= 1'b0;
    end else if (ld) begin
      held <= ld_char;
      pend <= 1'b1;
    end else if (ack) begin
      pend <= 1'b0;
    end
  end

  // R2: arrival raises the request
  p_arrival_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> pend);
  // R5: request persists until acknowledged
  p_pend_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);
  // R3: acknowledge without arrival clears
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (ack && !ld) |=> !pend);
  // R10: collision keeps the request high
  p_collide_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && ld) |=> pend);
endmodule

// File: rtl/keyin_port.sv
module keyin_port
  import keyin_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter int                DATA_W    = 16,
  parameter int                CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 24'h800000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid,
  input  logic [CHAR_W-1:0] src_char,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int PAD_W = DATA_W - CHAR_W;

  acc_kind_e         kind;
  logic              ack;
  logic [CHAR_W-1:0] held;

  keyin_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .cs   (bus_cs),
    .we   (bus_we),
    .addr (bus_addr),
    .kind (kind)
  );

  keyin_rdpulse u_pulse (
    .clk    (clk),
    .rst    (rst),
    .rd_req (kind == ACC_READ),
    .ack    (ack)
  );

  keyin_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .ld      (src_valid),
    .ld_char (src_char),
    .ack     (ack),
    .held    (held),
    .pend    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (ack) rd_data <= {{PAD_W{1'b0}}, held};
  end

  // R4: upper data bits stay zero
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:CHAR_W] == '0);
  // R8: a write cycle never acknowledges
  p_write_no_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_cs && bus_we) |-> !ack);
  // R8/R9: read data changes only on an acknowledge
  p_data_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !ack |=> $stable(rd_data));
endmodule

// File: tb/keyin_port_tb.sv
`timescale 1ns/1ps
module keyin_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_valid = 1'b0;
  logic [7:0]  src_char = 8'h00;
  logic        bus_cs = 1'b0;
  logic        bus_we = 1'b0;
  logic [23:0] bus_addr = 24'h0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [23:0] HIT_A  = 24'h800000;
  localparam logic [23:0] MISS_A = 24'h800001;

  always #4 clk = ~clk;

  keyin_port u_dut (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_char(src_char),
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .rd_data(rd_data), .irq(irq)
  );

  // vector: {op[1:0], hit, char[7:0], exp_irq, exp_data[7:0]}
  // op 0 = inject, 1 = read, 2 = write, 3 = idle
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 1'b1, 8'h41, 1'b1, 8'h00},  // R2 arrival
    {2'd3, 1'b1, 8'h00, 1'b1, 8'h00},  // R5 idle keeps irq
    {2'd1, 1'b0, 8'h00, 1'b1, 8'h00},  // R9 miss read
    {2'd2, 1'b1, 8'h00, 1'b1, 8'h00},  // R8 write ignored
    {2'd1, 1'b1, 8'h00, 1'b0, 8'h41},  // R3 read clears
    {2'd1, 1'b1, 8'h00, 1'b0, 8'h41},  // R3 reread same char
    {2'd0, 1'b1, 8'h42, 1'b1, 8'h41},  // R2
    {2'd0, 1'b1, 8'h43, 1'b1, 8'h41},  // R6 overwrite
    {2'd1, 1'b1, 8'h00, 1'b0, 8'h43},  // R6 newest returned
    {2'd0, 1'b1, 8'h7E, 1'b1, 8'h43},  // R2
    {2'd1, 1'b1, 8'h00, 1'b0, 8'h7E}   // R3
  };

  task automatic check(input string tag, input logic eirq, input logic [7:0] edat);
    checks++;
    if (irq !== eirq || rd_data !== {8'h00, edat}) begin
      errors++;
      $display("FAIL %s: irq=%0b data=%h expected irq=%0b data=%h",
               tag, irq, rd_data, eirq, {8'h00, edat});
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic hit, input logic [7:0] ch);
    @(negedge clk);
    src_valid = (op == 2'd0);
    src_char  = ch;
    bus_cs    = (op == 2'd1) || (op == 2'd2);
    bus_we    = (op == 2'd2);
    bus_addr  = hit ? HIT_A : MISS_A;
    @(negedge clk);
    src_valid = 1'b0;
    bus_cs    = 1'b0;
    bus_we    = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 1'b0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19:18], VEC[i][17], VEC[i][16:9]);
      check($sformatf("R3/R4 vector %0d", i), VEC[i][8], VEC[i][7:0]);
    end

    // R7: held read, char arrives during it
    drive(2'd0, 1'b1, 8'h30);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = HIT_A;
    @(negedge clk);
    check("R7 first cycle acks", 1'b0, 8'h30);
    src_valid = 1'b1; src_char = 8'h31;
    @(negedge clk);
    src_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 no second ack", 1'b1, 8'h30);
    bus_cs = 1'b0;
    @(negedge clk);
    check("R7 irq after release", 1'b1, 8'h30);
    drive(2'd1, 1'b1, 8'h00);
    check("R7 later read", 1'b0, 8'h31);

    // R10: arrival collides with read start
    drive(2'd0, 1'b1, 8'h70);
    @(negedge clk);
    src_valid = 1'b1; src_char = 8'h71;
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = HIT_A;
    @(negedge clk);
    src_valid = 1'b0; bus_cs = 1'b0;
    check("R10 old char, irq kept", 1'b1, 8'h70);
    drive(2'd1, 1'b1, 8'h00);
    check("R10 new char read", 1'b0, 8'h71);

    // R1: reset mid-run
    drive(2'd0, 1'b1, 8'h44);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears", 1'b0, 8'h00);
    drive(2'd1, 1'b1, 8'h00);
    check("R1 holding cleared", 1'b0, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule